// File: doc/BRIEF.md
# Controller Start-Up and Configuration-Load Sequencer

This block brings a fieldbus slave controller out of power-up in a fixed order. A raw asynchronous reset clears it. It then keeps the controller core in reset until the clock generator reports lock. On FPGA targets it also waits for the configuration-done input. Both indications pass through a two-stage synchronizer first. Once the core is released, the sequencer asks an external serial-EEPROM loader for the configuration image over a level request with done and error replies. While that load runs, register reads arriving over the network link are already served whenever the link is up.

The process-data memory is locked until a load succeeds. Every memory request made before then is refused. Only a successful load does the following: it stores the configuration word, sets the loaded bit in the status register, unlocks the memory, reports the Init application state and raises the load-complete pin. On an error the sequencer waits a programmable number of cycles and requests the load again. A parameter selects between two variants. In the discrete variant, the host-side interface outputs stay undriven until the load has succeeded. In the soft-core variant, they are enabled as soon as the core leaves reset.

Top module: `boot_seq`

## Requirements
- R1: `core_rst_n_o` stays low until the clock-lock input is high and, when `FPGA_TARGET`=1, the config-done input is also high. It goes high on the third rising clock edge after both inputs are high: two synchronizer stages, then one state register.
- R2: `state_o` uses this encoding: 0 for reset, 1 for wait-for-lock, 2 for loading, 3 for loaded and 4 for load error. The state moves from 0 to 1 on the first clock after `arst_n` goes high.
- R3: `ld_req_o` is high exactly while the state is loading (2).
- R4: A `pm_req_i` sampled at a clock edge is answered on the next cycle. The answer is `pm_refuse_o` when the state at that edge was not loaded, and `pm_grant_o` when it was. The two answers are never high together.
- R5: A `reg_rd_i` sampled at a clock edge is answered on the next cycle. The answer is `reg_ack_o`, with `reg_data_o`, if `link_up_i` was high and the core was out of reset. Otherwise the answer is `reg_nak_o`. The load state plays no part in this.
- R6: When `ld_done_i` is high and `ld_err_i` is low while loading, the next state is loaded (3). At the same edge `ld_data_i` is captured. After that, bit 0 of the register at `STAT_ADDR` reads 1, and the register at `CFG_ADDR` reads the captured word, zero-extended. Before this, both read 0, and any other address always reads 0.
- R7: When `ld_err_i` is high while loading, the next state is load error (4), whatever `ld_done_i` holds. The state then stays at 4 for `RETRY_CYCLES` cycles and returns to loading. During that time the status bit reads 0 and the memory stays refused.
- R8: `ld_done_i` and `ld_err_i` have no effect in any state other than loading.
- R9: With `SOFT_CORE`=0, `host_oe_o` and `cfg_loaded_o` are low until the state is loaded and high from then on. With `SOFT_CORE`=1, `host_oe_o` goes high together with `core_rst_n_o`.
- R10: `app_state_o` is 0 before a successful load and 1 (Init) in the loaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| pll_lock_i | input | 1 | Clock generator lock, asynchronous |
| cfg_done_i | input | 1 | FPGA configuration done, asynchronous |
| link_up_i | input | 1 | Network link established |
| ld_req_o | output | 1 | Request to the EEPROM loader |
| ld_done_i | input | 1 | Loader finished |
| ld_err_i | input | 1 | Loader failed |
| ld_data_i | input | CFG_W | Configuration word from the loader |
| pm_req_i | input | 1 | Process-data memory request |
| pm_grant_o | output | 1 | Memory request accepted |
| pm_refuse_o | output | 1 | Memory request refused |
| reg_rd_i | input | 1 | Register read over the link |
| reg_addr_i | input | ADDR_W | Register address |
| reg_ack_o | output | 1 | Read served |
| reg_nak_o | output | 1 | Read rejected |
| reg_data_o | output | DATA_W | Read data |
| core_rst_n_o | output | 1 | Core reset, active low |
| host_oe_o | output | 1 | Output enable for the host interface pads |
| cfg_loaded_o | output | 1 | Load-complete pin value (meaningful when enabled) |
| app_state_o | output | 4 | Application state, 1 = Init |
| state_o | output | 3 | Sequencer state |

## Verification
A load can complete in the same cycle that a link register read and a memory request arrive. Both of those requests must be judged on the state before the completion edge. The bench drives `ld_done_i`, `reg_rd_i` to the status address and `pm_req_i` together. It then expects a refusal and a status bit of 0 in the reply cycle, and a grant and a bit of 1 on the very next request. A second collision puts the error and done inputs in the same cycle, and the error must take priority.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_WAIT_LOCK = 3'd1,
        ST_LOADING   = 3'd2,
        ST_LOADED    = 3'd3,
        ST_LOAD_ERR  = 3'd4
    } seq_state_e;

    localparam logic [3:0] APP_NONE = 4'd0;
    localparam logic [3:0] APP_INIT = 4'd1;
endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] st_d, st_q;
        always_comb begin
            st_d = {st_q[0], async_i[g]};
        end
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) st_q <= '0;
            else         st_q <= st_d;
        end
        assign sync_o[g] = st_q[1];
    end
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_seq_pkg::*;
#(
    parameter int CFG_W        = 16,
    parameter int RETRY_CYCLES = 16,
    parameter bit FPGA_TARGET  = 1'b1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             lock_s,
    input  logic             cfgdone_s,
    input  logic             ld_done_i,
    input  logic             ld_err_i,
    input  logic [CFG_W-1:0] ld_data_i,
    output seq_state_e       state_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             ld_req_o,
    output logic             core_rel_o,
    output logic             loaded_o
);
    localparam int CNT_W = (RETRY_CYCLES < 2) ? 1 : $clog2(RETRY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RETRY_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] cfg;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      ready;

    always_comb begin
        ready = lock_s && (cfgdone_s || !FPGA_TARGET);
        r_d   = r_q;
        unique case (r_q.state)
            ST_RESET:     r_d.state = ST_WAIT_LOCK;
            ST_WAIT_LOCK: if (ready) r_d.state = ST_LOADING;
            ST_LOADING: begin
                if (ld_err_i) begin
                    r_d.state = ST_LOAD_ERR;
                    r_d.cnt   = CNT_INIT;
                end else if (ld_done_i) begin
                    r_d.state = ST_LOADED;
                    r_d.cfg   = ld_data_i;
                end
            end
            ST_LOAD_ERR: begin
                if (r_q.cnt == '0) r_d.state = ST_LOADING;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            ST_LOADED:    r_d.state = ST_LOADED;
            default:      r_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '{state: ST_RESET, cnt: '0, cfg: '0};
        else         r_q <= r_d;
    end

    assign state_o    = r_q.state;
    assign cfg_o      = r_q.cfg;
    assign ld_req_o   = (r_q.state == ST_LOADING);
    assign core_rel_o = (r_q.state != ST_RESET) && (r_q.state != ST_WAIT_LOCK);
    assign loaded_o   = (r_q.state == ST_LOADED);
endmodule

// File: rtl/boot_access.sv
module boot_access
    import boot_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 16,
    parameter int                CFG_W     = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h110,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h140,
    parameter bit                SOFT_CORE = 1'b0
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              core_rel,
    input  logic              loaded,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              link_up_i,
    input  logic              pm_req_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    output logic              pm_grant_o,
    output logic              pm_refuse_o,
    output logic              reg_ack_o,
    output logic              reg_nak_o,
    output logic [DATA_W-1:0] reg_data_o,
    output logic              host_oe_o,
    output logic              cfg_loaded_o,
    output logic [3:0]        app_state_o
);
    typedef struct packed {
        logic              grant;
        logic              refuse;
        logic              ack;
        logic              nak;
        logic [DATA_W-1:0] data;
    } acc_regs_t;

    acc_regs_t a_d, a_q;
    logic      rd_ok;

    always_comb begin
        rd_ok      = reg_rd_i && link_up_i && core_rel;
        a_d.grant  = pm_req_i && loaded;
        a_d.refuse = pm_req_i && !loaded;
        a_d.ack    = rd_ok;
        a_d.nak    = reg_rd_i && !rd_ok;
        a_d.data   = '0;
        if (rd_ok) begin
            if (reg_addr_i == STAT_ADDR)     a_d.data[0] = loaded;
            else if (reg_addr_i == CFG_ADDR) a_d.data    = DATA_W'(cfg);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) a_q <= '0;
        else         a_q <= a_d;
    end

    if (SOFT_CORE) begin : g_soft
        assign host_oe_o = core_rel;
    end else begin : g_discrete
        assign host_oe_o = loaded;
    end

    assign pm_grant_o   = a_q.grant;
    assign pm_refuse_o  = a_q.refuse;
    assign reg_ack_o    = a_q.ack;
    assign reg_nak_o    = a_q.nak;
    assign reg_data_o   = a_q.data;
    assign cfg_loaded_o = loaded && host_oe_o;
    assign app_state_o  = loaded ? APP_INIT : APP_NONE;
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter int                CFG_W        = 16,
    parameter int                RETRY_CYCLES = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR    = 12'h110,
    parameter logic [ADDR_W-1:0] CFG_ADDR     = 12'h140,
    parameter bit                FPGA_TARGET  = 1'b1,
    parameter bit                SOFT_CORE    = 1'b0
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              pll_lock_i,
    input  logic              cfg_done_i,
    input  logic              link_up_i,
    output logic              ld_req_o,
    input  logic              ld_done_i,
    input  logic              ld_err_i,
    input  logic [CFG_W-1:0]  ld_data_i,
    input  logic              pm_req_i,
    output logic              pm_grant_o,
    output logic              pm_refuse_o,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    output logic              reg_ack_o,
    output logic              reg_nak_o,
    output logic [DATA_W-1:0] reg_data_o,
    output logic              core_rst_n_o,
    output logic              host_oe_o,
    output logic              cfg_loaded_o,
    output logic [3:0]        app_state_o,
    output logic [2:0]        state_o
);
    logic [1:0]       sync_out;
    seq_state_e       state;
    logic [CFG_W-1:0] cfg;
    logic             core_rel;
    logic             loaded;

    boot_sync #(.W(2)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i ({cfg_done_i, pll_lock_i}),
        .sync_o  (sync_out)
    );

    boot_fsm #(
        .CFG_W        (CFG_W),
        .RETRY_CYCLES (RETRY_CYCLES),
        .FPGA_TARGET  (FPGA_TARGET)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .lock_s     (sync_out[0]),
        .cfgdone_s  (sync_out[1]),
        .ld_done_i  (ld_done_i),
        .ld_err_i   (ld_err_i),
        .ld_data_i  (ld_data_i),
        .state_o    (state),
        .cfg_o      (cfg),
        .ld_req_o   (ld_req_o),
        .core_rel_o (core_rel),
        .loaded_o   (loaded)
    );

    boot_access #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CFG_W     (CFG_W),
        .STAT_ADDR (STAT_ADDR),
        .CFG_ADDR  (CFG_ADDR),
        .SOFT_CORE (SOFT_CORE)
    ) u_access (
        .clk          (clk),
        .arst_n       (arst_n),
        .core_rel     (core_rel),
        .loaded       (loaded),
        .cfg          (cfg),
        .link_up_i    (link_up_i),
        .pm_req_i     (pm_req_i),
        .reg_rd_i     (reg_rd_i),
        .reg_addr_i   (reg_addr_i),
        .pm_grant_o   (pm_grant_o),
        .pm_refuse_o  (pm_refuse_o),
        .reg_ack_o    (reg_ack_o),
        .reg_nak_o    (reg_nak_o),
        .reg_data_o   (reg_data_o),
        .host_oe_o    (host_oe_o),
        .cfg_loaded_o (cfg_loaded_o),
        .app_state_o  (app_state_o)
    );

    assign core_rst_n_o = core_rel;
    assign state_o      = state;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
    input logic       clk,
    input logic       arst_n,
    input logic       pll_lock_i,
    input logic       ld_done_i,
    input logic       ld_err_i,
    input logic       pm_req_i,
    input logic       reg_rd_i,
    input logic       link_up_i,
    input logic       ld_req_o,
    input logic       pm_grant_o,
    input logic       pm_refuse_o,
    input logic       reg_ack_o,
    input logic       reg_nak_o,
    input logic       core_rst_n_o,
    input logic       host_oe_o,
    input logic       cfg_loaded_o,
    input logic [3:0] app_state_o,
    input logic [2:0] state_o
);
    // R1
    rst_lock_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst_n_o) |-> $past(pll_lock_i, 2));

    // R3
    req_unloaded_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ld_req_o |-> (app_state_o == 4'd0) && core_rst_n_o);

    // R4
    grant_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !(pm_grant_o && pm_refuse_o));

    // R4
    grant_src_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (pm_grant_o || pm_refuse_o) |-> $past(pm_req_i));

    // R5
    reg_ack_chk: assert property (@(posedge clk) disable iff (!arst_n)
        reg_ack_o |-> $past(reg_rd_i && link_up_i) && !reg_nak_o);

    // R6
    load_done_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(app_state_o == 4'd1) |-> $past(ld_done_i && !ld_err_i));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_o == 3'd4) |-> !ld_req_o && (app_state_o == 4'd0) && !pm_grant_o);

    // R9
    pin_oe_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cfg_loaded_o |-> host_oe_o && (app_state_o == 4'd1));
endmodule

bind boot_seq boot_seq_chk u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .pll_lock_i   (pll_lock_i),
    .ld_done_i    (ld_done_i),
    .ld_err_i     (ld_err_i),
    .pm_req_i     (pm_req_i),
    .reg_rd_i     (reg_rd_i),
    .link_up_i    (link_up_i),
    .ld_req_o     (ld_req_o),
    .pm_grant_o   (pm_grant_o),
    .pm_refuse_o  (pm_refuse_o),
    .reg_ack_o    (reg_ack_o),
    .reg_nak_o    (reg_nak_o),
    .core_rst_n_o (core_rst_n_o),
    .host_oe_o    (host_oe_o),
    .cfg_loaded_o (cfg_loaded_o),
    .app_state_o  (app_state_o),
    .state_o      (state_o)
);

// File: tb/boot_seq_tb.sv
module boot_seq_tb;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int CFG_W  = 16;
    localparam int RETRY  = 16;
    localparam logic [ADDR_W-1:0] STAT = 12'h110;
    localparam logic [ADDR_W-1:0] CFGA = 12'h140;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic pll_lock = 1'b0, cfg_done = 1'b0, link_up = 1'b0;
    logic ld_done = 1'b0, ld_err = 1'b0;
    logic [CFG_W-1:0] ld_data = '0;
    logic pm_req = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;

    logic ld_req, pm_grant, pm_refuse, reg_ack, reg_nak, core_rst_n, host_oe, cfg_loaded;
    logic [DATA_W-1:0] reg_data;
    logic [3:0] app_state;
    logic [2:0] state;

    logic s_ld_req, s_pm_grant, s_pm_refuse, s_reg_ack, s_reg_nak, s_core_rst_n, s_host_oe, s_cfg_loaded;
    logic [DATA_W-1:0] s_reg_data;
    logic [3:0] s_app_state;
    logic [2:0] s_state;

    int n_chk = 0;
    int n_bad = 0;
    logic [CFG_W-1:0] exp_cfg = '0;
    logic exp_loaded = 1'b0;

    always #4 clk = ~clk;

    boot_seq #(.RETRY_CYCLES(RETRY)) u_dut (
        .clk(clk), .arst_n(arst_n), .pll_lock_i(pll_lock), .cfg_done_i(cfg_done),
        .link_up_i(link_up), .ld_req_o(ld_req), .ld_done_i(ld_done), .ld_err_i(ld_err),
        .ld_data_i(ld_data), .pm_req_i(pm_req), .pm_grant_o(pm_grant), .pm_refuse_o(pm_refuse),
        .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_ack_o(reg_ack), .reg_nak_o(reg_nak),
        .reg_data_o(reg_data), .core_rst_n_o(core_rst_n), .host_oe_o(host_oe),
        .cfg_loaded_o(cfg_loaded), .app_state_o(app_state), .state_o(state));

    boot_seq #(.RETRY_CYCLES(RETRY), .SOFT_CORE(1'b1)) u_dut_soft (
        .clk(clk), .arst_n(arst_n), .pll_lock_i(pll_lock), .cfg_done_i(cfg_done),
        .link_up_i(link_up), .ld_req_o(s_ld_req), .ld_done_i(ld_done), .ld_err_i(ld_err),
        .ld_data_i(ld_data), .pm_req_i(pm_req), .pm_grant_o(s_pm_grant), .pm_refuse_o(s_pm_refuse),
        .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_ack_o(s_reg_ack), .reg_nak_o(s_reg_nak),
        .reg_data_o(s_reg_data), .core_rst_n_o(s_core_rst_n), .host_oe_o(s_host_oe),
        .cfg_loaded_o(s_cfg_loaded), .app_state_o(s_app_state), .state_o(s_state));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a,
                                                 input logic ld, input logic [CFG_W-1:0] c);
        if (a == STAT)      return {{(DATA_W-1){1'b0}}, ld};
        else if (a == CFGA) return ld ? DATA_W'(c) : '0;
        else                return '0;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        pm_req = 1'b0; reg_rd = 1'b0; ld_done = 1'b0; ld_err = 1'b0;
    endtask

    // random access cycle: link reads and memory requests, checked against the bench model
    task automatic rand_cycle(input logic allow_err_chk);
        logic p, r, l;
        logic [ADDR_W-1:0] a;
        int sel;
        p = 1'($urandom);
        r = 1'($urandom);
        l = 1'($urandom);
        sel = int'($urandom % 3);
        a = (sel == 0) ? STAT : (sel == 1) ? CFGA : ADDR_W'($urandom);
        pm_req = p; reg_rd = r; link_up = l; reg_addr = a;
        tick();
        chk("R4 grant", 32'(pm_grant), 32'(p & exp_loaded));
        chk("R4 refuse", 32'(pm_refuse), 32'(p & ~exp_loaded));
        chk("R5 ack", 32'(reg_ack), 32'(r & l));
        chk("R5 nak", 32'(reg_nak), 32'(r & ~l));
        if (r && l) chk("R6 read data", 32'(reg_data), 32'(exp_rd(a, exp_loaded, exp_cfg)));
        if (allow_err_chk) chk("R7 state held", 32'(state), 32'd4);
    endtask

    initial begin : wdog
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        @(negedge clk);
        chk("R2 reset state", 32'(state), 32'd0);
        chk("R1 reset core", 32'(core_rst_n), 32'd0);
        chk("R9 reset oe", 32'(host_oe), 32'd0);
        chk("R3 reset req", 32'(ld_req), 32'd0);
        arst_n = 1'b1;
        tick();
        chk("R2 wait-lock", 32'(state), 32'd1);

        // link up while core in reset: read is rejected (R5)
        link_up = 1'b1; reg_rd = 1'b1; reg_addr = STAT;
        tick();
        chk("R5 nak in reset", 32'(reg_nak), 32'd1);
        reg_rd = 1'b0;

        // lock alone is not enough on FPGA target (R1)
        pll_lock = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        chk("R1 waits cfg-done", 32'(core_rst_n), 32'd0);
        chk("R1 still waiting", 32'(state), 32'd1);

        // done on the loader outside the loading state is ignored (R8)
        ld_done = 1'b1; ld_data = 16'hBEEF;
        tick();
        ld_done = 1'b0;
        chk("R8 done ignored", 32'(state), 32'd1);

        cfg_done = 1'b1;
        tick(); tick();
        chk("R1 two sync stages", 32'(core_rst_n), 32'd0);
        tick();
        chk("R1 release", 32'(core_rst_n), 32'd1);
        chk("R2 loading", 32'(state), 32'd2);
        chk("R3 request", 32'(ld_req), 32'd1);
        chk("R9 discrete oe off", 32'(host_oe), 32'd0);
        chk("R9 soft oe on", 32'(s_host_oe), 32'd1);
        chk("R10 no init yet", 32'(app_state), 32'd0);

        // random traffic during the load
        for (int i = 0; i < 150; i++) rand_cycle(1'b0);
        quiet();

        // error and done together: error wins (R7)
        ld_err = 1'b1; ld_done = 1'b1; ld_data = 16'h1111;
        tick();
        quiet();
        chk("R7 error state", 32'(state), 32'd4);
        chk("R3 no request", 32'(ld_req), 32'd0);
        for (int i = 0; i < RETRY - 1; i++) begin
            if (i == 3) ld_done = 1'b1;
            if (i == 4) ld_done = 1'b0;
            rand_cycle(1'b1);
        end
        quiet();
        tick();
        chk("R7 retry loading", 32'(state), 32'd2);
        chk("R7 request again", 32'(ld_req), 32'd1);

        // completion collides with a status read and a memory request
        ld_done = 1'b1; ld_data = 16'hA5C3;
        reg_rd = 1'b1; reg_addr = STAT; link_up = 1'b1; pm_req = 1'b1;
        tick();
        ld_done = 1'b0;
        chk("R6 loaded", 32'(state), 32'd3);
        chk("R4 refuse at edge", 32'(pm_refuse), 32'd1);
        chk("R5 ack at edge", 32'(reg_ack), 32'd1);
        chk("R6 old status", 32'(reg_data), 32'd0);
        exp_loaded = 1'b1; exp_cfg = 16'hA5C3;
        tick();
        chk("R4 grant after", 32'(pm_grant), 32'd1);
        chk("R6 status bit", 32'(reg_data), 32'd1);
        reg_addr = CFGA;
        tick();
        chk("R6 cfg word", 32'(reg_data), 32'hA5C3);
        chk("R9 oe", 32'(host_oe), 32'd1);
        chk("R9 loaded pin", 32'(cfg_loaded), 32'd1);
        chk("R10 init", 32'(app_state), 32'd1);
        chk("R3 request off", 32'(ld_req), 32'd0);

        // late error after load is ignored (R8)
        quiet();
        ld_err = 1'b1;
        tick();
        ld_err = 1'b0;
        chk("R8 err ignored", 32'(state), 32'd3);

        for (int i = 0; i < 150; i++) rand_cycle(1'b0);
        quiet();

        link_up = 1'b0; reg_rd = 1'b1;
        tick();
        chk("R5 nak link down", 32'(reg_nak), 32'd1);
        reg_rd = 1'b0;
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule